// File: doc/BRIEF.md
# Paired-Block Interrupt Collector

This block gathers the interrupt causes of eight serial channels, which are grouped two to a block in four blocks. Each block keeps an 8-bit status byte. Single-cycle set and clear pulses from the channels and from the block-level sources change that byte. Each block also has an 8-bit mask byte that the host writes. Each of the two request outputs serves a pair of blocks. A request line is high while either block of its pair has a cause that is both pending and enabled.

The host reaches the block through one read/write strobe pair, a 2-bit space select and an 8-bit address. Space 0 is the register space. There, each block owns a 64-byte window selected by the top two address bits. Offset 0x0A in that window reads the status byte and writes the mask byte. Space 1 (identification) and space 3 (byte memory) accept the interrupt vector byte at address 1. Space 2 (interrupt) answers acknowledge reads with that vector and leaves every status bit untouched.

Top module: `paired_irq_collector`

## Requirements
- R1: After reset, every status byte, every mask byte and the vector are zero, both request lines are low and the read data is zero.
- R2: Channel c carries its pulses at bit positions 3c (transmit ready), 3c+1 (receive ready) and 3c+2 (break) of `ch_set`/`ch_clr`. These pulses act on status bit (c mod 2)*4 + kind of block c/2, where kind is 0 for transmit ready, 1 for receive ready and 2 for break. Block b carries its counter-ready pulse at position 2b and its input-change pulse at position 2b+1 of `blk_set`/`blk_clr`. These pulses act on status bits 3 and 7 of block b. A pulse changes the status on the next clock edge.
- R3: A clear pulse resets its status bit. If a set pulse and a clear pulse reach the same bit in one cycle, the bit ends up set.
- R4: A write in space 0 at offset 0x0A of block b's window (address b*64 + 0x0A) loads the mask of block b. A read at that address returns the status byte and never the mask. A write in space 0 at any other offset leaves the mask unchanged.
- R5: Request line 0 is high when block 0 or block 1 has a bit set in both its status and its mask. Request line 1 does the same for blocks 2 and 3. Each line is registered and follows a status or mask change one clock later.
- R6: A write at address 1 in space 1 or space 3 loads the vector byte. A write at any other address, or in space 0 or space 2, leaves the vector unchanged.
- R7: In space 2, a read at address 0 or 2 returns the vector byte and changes no status bit and no request line. A read at any other address in that space returns zero.
- R8: Read data appears on `host_rdata` on the clock edge that samples the read strobe. Space 1 and space 3 reads, and space 0 reads at offsets other than 0x0A, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_space | input | 2 | 0 register, 1 identification, 2 interrupt, 3 byte memory |
| host_addr | input | 8 | Address within the selected space |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| ch_set | input | 24 | Per-channel set pulses, three per channel |
| ch_clr | input | 24 | Per-channel clear pulses, three per channel |
| blk_set | input | 8 | Per-block set pulses: counter ready, input change |
| blk_clr | input | 8 | Per-block clear pulses: counter ready, input change |
| irq | output | 2 | Request lines, one per block pair |

## Verification
A status bit at the wrong position, or one held too long, appears at the ports in two ways. The status read of the affected block returns the wrong byte. Once the host enables that bit in the mask, the request line of the wrong pair rises one clock later, or the right line fails to fall. The bench checks the mask-to-request delay at exactly one cycle by sampling both before and after that edge. A vector register that is loaded from the wrong space, or an acknowledge that clears a status bit, shows up on the next acknowledge read or on the next status read.

// File: rtl/paired_irq_collector.sv
module paired_irq_collector #(
  parameter int NCHAN    = 8,
  parameter int AW       = 8,
  parameter int STAT_OFS = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_rd,
  input  logic                 host_wr,
  input  logic [1:0]           host_space,
  input  logic [AW-1:0]        host_addr,
  input  logic [7:0]           host_wdata,
  output logic [7:0]           host_rdata,
  input  logic [NCHAN*3-1:0]   ch_set,
  input  logic [NCHAN*3-1:0]   ch_clr,
  input  logic [NCHAN-1:0]     blk_set,
  input  logic [NCHAN-1:0]     blk_clr,
  output logic [NCHAN/4-1:0]   irq
);
  localparam int NBLK = NCHAN / 2;
  localparam int NIRQ = NBLK / 2;
  localparam int BW   = $clog2(NBLK);
  localparam int LW   = AW - BW;
  localparam int SW   = NBLK * 8;

  logic [SW-1:0] stat_q, mask_q, sv, cv, pend;
  logic [7:0]    vec_q, rd_val;
  logic [BW-1:0] bsel;
  logic          at_stat, ack_hit, mask_we, vec_we;

  assign bsel    = host_addr[AW-1 -: BW];
  assign at_stat = host_addr[LW-1:0] == LW'(STAT_OFS);
  assign ack_hit = (host_addr < AW'(2*NIRQ)) && !host_addr[0];
  assign mask_we = host_wr && host_space == 2'd0 && at_stat;
  assign vec_we  = host_wr && host_space[0] && host_addr == AW'(1);
  assign pend    = stat_q & mask_q;

  always_comb begin
    sv = '0;
    cv = '0;
    for (int c = 0; c < NCHAN; c++)
      for (int k = 0; k < 3; k++) begin
        sv[(c/2)*8 + (c%2)*4 + k] = ch_set[c*3+k];
        cv[(c/2)*8 + (c%2)*4 + k] = ch_clr[c*3+k];
      end
    for (int b = 0; b < NBLK; b++) begin
      sv[b*8+3] = blk_set[b*2];
      sv[b*8+7] = blk_set[b*2+1];
      cv[b*8+3] = blk_clr[b*2];
      cv[b*8+7] = blk_clr[b*2+1];
    end
  end

  always_comb begin
    case (host_space)
      2'd0:    rd_val = at_stat ? stat_q[{bsel, 3'b000} +: 8] : 8'h00;
      2'd2:    rd_val = ack_hit ? vec_q : 8'h00;
      default: rd_val = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q     <= '0;
      mask_q     <= '0;
      vec_q      <= '0;
      host_rdata <= '0;
    end else begin
      stat_q <= (stat_q & ~cv) | sv;
      if (mask_we) mask_q[{bsel, 3'b000} +: 8] <= host_wdata;
      if (vec_we)  vec_q <= host_wdata;
      if (host_rd) host_rdata <= rd_val;
    end
  end

  for (genvar i = 0; i < NIRQ; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq[i] <= 1'b0;
      else        irq[i] <= |pend[i*16 +: 16];
    end

    // R5
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(stat_q[i*16 +: 16] & mask_q[i*16 +: 16])) |=> irq[i]);
    // R5
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(stat_q[i*16 +: 16] & mask_q[i*16 +: 16])) |=> !irq[i]);
  end

  for (genvar j = 0; j < SW; j++) begin : g_bit
    // R3
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sv[j] |=> stat_q[j]);
    // R3
    clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cv[j] && !sv[j]) |=> !stat_q[j]);
  end

  // R6
  vec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && (host_space == 2'd1 || host_space == 2'd3) && host_addr == AW'(1))
      |=> vec_q == $past(host_wdata));
  // R6
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && host_addr == AW'(1) && host_space[0]) |=> $stable(vec_q));
  // R7
  ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_space == 2'd2 && !(|sv) && !(|cv)) |=> $stable(stat_q));
  // R4
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && host_space == 2'd0 && host_addr[LW-1:0] == LW'(STAT_OFS)) |=> $stable(mask_q));
endmodule

// File: tb/test_paired_irq_collector.sv
module test_paired_irq_collector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_rd = 1'b0, host_wr = 1'b0;
  logic [1:0]  host_space = '0;
  logic [7:0]  host_addr = '0, host_wdata = '0;
  logic [7:0]  host_rdata;
  logic [23:0] ch_set = '0, ch_clr = '0;
  logic [7:0]  blk_set = '0, blk_clr = '0;
  logic [1:0]  irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] m_st [4];
  logic [7:0] m_mk [4];
  logic [7:0] m_vec;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       rd_d = 1'b0;

  always #4 clk = ~clk;

  paired_irq_collector i_paired_irq_collector (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
    .host_space(host_space), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .ch_set(ch_set), .ch_clr(ch_clr),
    .blk_set(blk_set), .blk_clr(blk_clr), .irq(irq));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] model_irq();
    logic [1:0] r;
    r[0] = |((m_st[0] & m_mk[0]) | (m_st[1] & m_mk[1]));
    r[1] = |((m_st[2] & m_mk[2]) | (m_st[3] & m_mk[3]));
    return r;
  endfunction

  always @(posedge clk) rd_d <= host_rd;
  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) chk("R8 unexpected read", host_rdata, 8'hxx);
      else chk(tag_q.pop_front(), host_rdata, exp_q.pop_front());
    end
  end

  task automatic rd(input string req, input logic [1:0] sp, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    host_rd = 1'b1; host_space = sp; host_addr = a;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sp, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_space = sp; host_addr = a; host_wdata = d;
    if (sp == 2'd0 && a[5:0] == 6'h0A) m_mk[a[7:6]] = d;
    if (sp[0] && a == 8'd1) m_vec = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic pulse(input logic [23:0] cs, input logic [23:0] cc,
                       input logic [7:0] bs, input logic [7:0] bc);
    @(negedge clk);
    ch_set = cs; ch_clr = cc; blk_set = bs; blk_clr = bc;
    for (int c = 0; c < 8; c++)
      for (int k = 0; k < 3; k++) begin
        if (cc[c*3+k]) m_st[c/2][(c%2)*4+k] = 1'b0;
        if (cs[c*3+k]) m_st[c/2][(c%2)*4+k] = 1'b1;
      end
    for (int b = 0; b < 4; b++) begin
      if (bc[b*2])   m_st[b][3] = 1'b0;
      if (bc[b*2+1]) m_st[b][7] = 1'b0;
      if (bs[b*2])   m_st[b][3] = 1'b1;
      if (bs[b*2+1]) m_st[b][7] = 1'b1;
    end
    @(negedge clk);
    ch_set = '0; ch_clr = '0; blk_set = '0; blk_clr = '0;
  endtask

  task automatic read_all_status(input string req);
    for (int b = 0; b < 4; b++) rd(req, 2'd0, 8'(b*64 + 10), m_st[b]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 4; b++) begin m_st[b] = '0; m_mk[b] = '0; end
    m_vec = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq", {6'd0, irq}, 8'h00);
    chk("R1 rdata", host_rdata, 8'h00);
    read_all_status("R1 status");
    rd("R1 vector", 2'd2, 8'd0, 8'h00);

    pulse(24'h000001, '0, '0, '0);
    rd("R2 ch0 tx", 2'd0, 8'h0A, 8'h01);
    pulse(24'd1 << 16, '0, '0, '0);
    pulse(24'd1 << 11, '0, 8'b1000_0000 | 8'b0100_0000, '0);
    read_all_status("R2 mapping");
    chk("R5 masked off", {6'd0, irq}, 8'h00);

    wr(2'd0, 8'h4A, 8'h40);
    chk("R5 delay before", {6'd0, irq}, 8'h00);
    @(negedge clk);
    chk("R5 line0 up", {6'd0, irq}, {6'd0, model_irq()});
    rd("R4 status not mask", 2'd0, 8'h4A, m_st[1]);
    wr(2'd0, 8'h0B, 8'hFF);
    rd("R8 other offset", 2'd0, 8'h0B, 8'h00);
    wr(2'd0, 8'hCA, 8'h08);
    @(negedge clk);
    chk("R5 line1 up", {6'd0, irq}, 8'h03);

    wr(2'd0, 8'h0A, 8'h20);
    pulse(24'd1 << 4, 24'd1 << 4, '0, '0);
    rd("R3 set wins", 2'd0, 8'h0A, 8'h21);
    pulse('0, 24'd1 << 11, '0, '0);
    rd("R3 clear", 2'd0, 8'h4A, 8'h00);
    chk("R5 pair via block0", {6'd0, irq}, 8'h03);
    pulse('0, 24'd1 << 4, '0, '0);
    @(negedge clk);
    chk("R5 line0 down", {6'd0, irq}, {6'd0, model_irq()});
    pulse('0, '0, '0, 8'b0100_0000);
    @(negedge clk);
    chk("R5 line1 down", {6'd0, irq}, 8'h00);
    pulse('0, '0, 8'b0100_0000, '0);
    wr(2'd0, 8'hCA, 8'h80);
    @(negedge clk);
    chk("R5 input change", {6'd0, irq}, 8'h02);

    wr(2'd1, 8'd1, 8'hA5);
    rd("R6 id space", 2'd2, 8'd0, 8'hA5);
    wr(2'd2, 8'd1, 8'h11);
    wr(2'd0, 8'd1, 8'h22);
    wr(2'd1, 8'd3, 8'h33);
    rd("R6 ignored", 2'd2, 8'd2, 8'hA5);
    wr(2'd3, 8'd1, 8'h3C);
    rd("R7 ack line0", 2'd2, 8'd0, 8'h3C);
    rd("R7 ack line1", 2'd2, 8'd2, 8'h3C);
    rd("R7 other", 2'd2, 8'd1, 8'h00);
    rd("R7 far", 2'd2, 8'd4, 8'h00);
    read_all_status("R7 no clear");
    chk("R7 irq kept", {6'd0, irq}, {6'd0, model_irq()});
    rd("R8 id read", 2'd1, 8'd1, 8'h00);
    rd("R8 mem read", 2'd3, 8'd1, 8'h00);

    repeat (3) @(negedge clk);
    chk("R8 queue drained", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule